// File: doc/BRIEF.md
# Space vector PWM timing generator

This block turns a two-axis stationary-frame voltage command into the three compare values that a center-aligned PWM stage needs for a three-phase inverter bridge. The command arrives as signed fixed-point alpha and beta components that are already normalized to the DC bus, so a magnitude of 1.0 touches the circle inscribed in the voltage hexagon. A one-cycle start strobe also captures the PWM period in clock ticks. After a fixed latency the block returns one compare value per phase, the sector in which the command lies and a one-cycle done flag.

Inside, the command is passed through an inverse Clarke transform whose inputs are swapped, which rotates it by 90 degrees. Three sign bits of the rotated references select the sector. The two active-vector times come from three shared intermediates. They are spread over the phases in a sector-dependent order and converted into half-period edge offsets. A downstream PWM unit can then compare these offsets against an up/down counter. That counter and dead-time insertion belong to other blocks.

The pipeline takes a new command on every clock. Each command carries its own period through the pipeline, so the period may change from one command to the next.

Top module: `svm_timing_gen`

## Requirements
- R1: Inputs are signed Q2.(W-2) values, with 1.0 = 2^(W-2). The rotated references are r1 = Vbeta, r2 = (sqrt3·Valpha − Vbeta)/2 and r3 = (−sqrt3·Valpha − Vbeta)/2. The sector code is {r3>0, r2>0, r1>0}, with r3 as bit 2, and the `sector` output carries that code (1 to 6) for a nonzero vector.
- R2: With X = Vbeta, Y = (Vbeta + sqrt3·Valpha)/2 and Z = (Vbeta − sqrt3·Valpha)/2, the active times (t1, t2) are: sector 1 (Z, Y), sector 2 (Y, −X), sector 3 (−Z, X), sector 4 (−X, Z), sector 5 (X, −Y), sector 6 (−Y, −Z).
- R3: The first phase gets duty d0 = (1 − t1 − t2)/2, the second d0 + t1 and the third d0 + t1 + t2. By sector, the order (first, second, third) is: 1 (b,a,c), 2 (a,c,b), 3 (a,b,c), 4 (c,b,a), 5 (b,c,a), 6 (c,a,b). The compare values therefore fall from the first phase to the third.
- R4: Each phase compare value is (P − d·P)/2 in clock ticks, where P is the period captured with the start strobe. It is exact to within a few ticks of fixed-point rounding.
- R5: Every compare value is clamped to the range 0 to P, so an over-range command saturates instead of wrapping.
- R6: A sector code of 0 or 7 gives `sector` = 0 and the zero-vector output, which is 50 % duty on every phase: each compare equals floor((P − floor(P/2))/2).
- R7: Compare values, sector and done update on the third rising edge after the edge that samples `start`. `done` is high for exactly one cycle per start, and a start is accepted on every cycle.
- R8: Each command uses the period sampled together with it, so commands in flight with different periods do not affect one another.
- R9: During and right after reset, `done` is 0, every compare value is 0 and `sector` is 0.
- R10: In any cycle without `done`, the compare values and `sector` hold their previous values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Samples valpha, vbeta and period |
| valpha | input | W | Alpha component, signed Q2.(W-2) |
| vbeta | input | W | Beta component, signed Q2.(W-2) |
| period | input | PW | PWM period in clock ticks |
| cmp_a | output | PW | Edge offset for phase a |
| cmp_b | output | PW | Edge offset for phase b |
| cmp_c | output | PW | Edge offset for phase c |
| sector | output | 3 | Sector code 1..6, or 0 for the zero vector |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with W = 16 (Q2.14 inputs) and PW = 16. These are small enough to check every result against a real-valued model, and wide enough for periods up to 60000 ticks. It sweeps the command angle in 15-degree steps at four magnitudes up to the inscribed circle and at three periods, which reaches all six sectors and every phase ordering. An over-range sweep drives the clamp. Back-to-back commands with different periods, the exact zero vector with an odd period, and idle cycles after a result cover the pipeline, the zero-vector mapping and the hold behaviour.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
// Shared types for the space vector timing generator.
// Assumes three phases named a, b and c, and sector codes 1..6 on three sign bits.
package svm_pkg;

    typedef enum logic [1:0] {PH_A = 2'd0, PH_B = 2'd1, PH_C = 2'd2} phase_e;

    // Phase that receives the shortest, middle and longest duty
    typedef struct packed {
        phase_e first;
        phase_e second;
        phase_e third;
    } order_t;

    // Phase ordering for each sector code; illegal codes fall back to a,b,c
    function automatic order_t sector_order(input logic [2:0] code);
        case (code)
            3'd1:    return '{PH_B, PH_A, PH_C};
            3'd2:    return '{PH_A, PH_C, PH_B};
            3'd3:    return '{PH_A, PH_B, PH_C};
            3'd4:    return '{PH_C, PH_B, PH_A};
            3'd5:    return '{PH_B, PH_C, PH_A};
            3'd6:    return '{PH_C, PH_A, PH_B};
            default: return '{PH_A, PH_B, PH_C};
        endcase
    endfunction

endpackage

// File: rtl/svm_ref_rotate.sv
`timescale 1ns/1ps
// Pipeline stage 2: forms the shared intermediates X, Y, Z and the sector code.
// Uses the swapped-input inverse Clarke: r1 = X, r2 = -Z, r3 = -Y.
// Assumes inputs are signed Q2.(W-2), normalized to the DC bus.
module svm_ref_rotate #(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W-1:0] alpha_i,
    input  logic signed [W-1:0] beta_i,
    input  logic [PW-1:0]       per_i,
    output logic                vld_o,
    output logic signed [W+1:0] x_o,
    output logic signed [W+1:0] y_o,
    output logic signed [W+1:0] z_o,
    output logic [2:0]          code_o,
    output logic [PW-1:0]       per_o
);
    localparam int FRAC = W - 2;
    localparam int IW   = W + 2;
    localparam int PRW  = W + IW;
    localparam int KINT = $rtoi(0.8660254037844386 * (2.0 ** FRAC) + 0.5);
    localparam logic signed [IW-1:0] KCOEF = IW'(KINT);

    logic signed [PRW-1:0] prod;
    logic signed [IW-1:0]  kp;
    logic signed [IW-1:0]  beta_x;
    logic signed [IW-1:0]  half_b;
    logic signed [IW-1:0]  y_c;
    logic signed [IW-1:0]  z_c;
    logic [2:0]            code_c;

    // Scale alpha by sqrt3/2 and build Y, Z and the sign-bit code
    always_comb begin
        prod   = PRW'(alpha_i) * PRW'(KCOEF);
        kp     = IW'(prod >>> FRAC);
        beta_x = IW'(beta_i);
        half_b = beta_x >>> 1;
        y_c    = half_b + kp;
        z_c    = half_b - kp;
        // r3 > 0 <=> Y < 0 ; r2 > 0 <=> Z < 0 ; r1 > 0 <=> X > 0
        code_c = {y_c[IW-1], z_c[IW-1], (!beta_x[IW-1] && (beta_x != '0))};
    end

    // Register the intermediates with their period and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            x_o    <= '0;
            y_o    <= '0;
            z_o    <= '0;
            code_o <= '0;
            per_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                x_o    <= beta_x;
                y_o    <= y_c;
                z_o    <= z_c;
                code_o <= code_c;
                per_o  <= per_i;
            end
        end
    end
endmodule

// File: rtl/svm_sector_times.sv
`timescale 1ns/1ps
// Pipeline stage 3: picks the two active times for the sector and builds the
// three phase duties (fractions of the period, Q.(W-2)) in sector order.
// Codes 0 and 7 force both active times to zero, giving 50 % on all phases.
module svm_sector_times
    import svm_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W+1:0] x_i,
    input  logic signed [W+1:0] y_i,
    input  logic signed [W+1:0] z_i,
    input  logic [2:0]          code_i,
    input  logic [PW-1:0]       per_i,
    output logic                vld_o,
    output logic signed [W+1:0] duty_o [3],
    output logic [2:0]          sect_o,
    output logic [PW-1:0]       per_o
);
    localparam int FRAC = W - 2;
    localparam int IW   = W + 2;
    localparam logic signed [IW-1:0] ONE = IW'(2 ** FRAC);

    logic signed [IW-1:0] t1;
    logic signed [IW-1:0] t2;
    logic signed [IW-1:0] base_d;
    logic signed [IW-1:0] mid_d;
    logic signed [IW-1:0] top_d;
    logic [2:0]           sect_c;
    order_t               ord;
    logic signed [IW-1:0] duty_c [3];

    // Select active times per sector and form the three duty levels
    always_comb begin
        ord    = sector_order(code_i);
        sect_c = code_i;
        case (code_i)
            3'd1:    begin t1 = z_i;  t2 = y_i;  end
            3'd2:    begin t1 = y_i;  t2 = -x_i; end
            3'd3:    begin t1 = -z_i; t2 = x_i;  end
            3'd4:    begin t1 = -x_i; t2 = z_i;  end
            3'd5:    begin t1 = x_i;  t2 = -y_i; end
            3'd6:    begin t1 = -y_i; t2 = -z_i; end
            default: begin t1 = '0;   t2 = '0;   sect_c = 3'd0; end
        endcase
        base_d = (ONE - t1 - t2) >>> 1;
        mid_d  = base_d + t1;
        top_d  = mid_d + t2;
    end

    // Route the duty levels to phases according to the sector order
    for (genvar p = 0; p < 3; p++) begin : g_route
        always_comb begin
            if (ord.first == phase_e'(p))       duty_c[p] = base_d;
            else if (ord.second == phase_e'(p)) duty_c[p] = mid_d;
            else                                duty_c[p] = top_d;
        end
    end

    // Register duties, sector and period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            sect_o <= '0;
            per_o  <= '0;
            for (int k = 0; k < 3; k++) duty_o[k] <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sect_o <= sect_c;
                per_o  <= per_i;
                for (int k = 0; k < 3; k++) duty_o[k] <= duty_c[k];
            end
        end
    end
endmodule

// File: rtl/svm_compare_gen.sv
`timescale 1ns/1ps
// Pipeline stage 4: turns each phase duty into a center-aligned edge offset
// (period - on-time) / 2, clamped to 0..period, and registers the outputs.
// Assumes duty is a signed fraction with W-2 fractional bits.
module svm_compare_gen #(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W+1:0] duty_i [3],
    input  logic [2:0]          sect_i,
    input  logic [PW-1:0]       per_i,
    output logic [PW-1:0]       cmp_o [3],
    output logic [2:0]          sect_o,
    output logic                done_o
);
    localparam int FRAC = W - 2;
    localparam int IW   = W + 2;
    localparam int MW   = IW + PW + 1;

    logic signed [MW-1:0] per_s;
    logic [PW-1:0]        cmp_c [3];

    // Period as a signed wide operand
    always_comb per_s = $signed(MW'({1'b0, per_i}));

    for (genvar p = 0; p < 3; p++) begin : g_phase
        logic signed [MW-1:0] on_t;
        logic signed [MW-1:0] off_t;

        // On-time in ticks, inverted and halved, then clamped
        always_comb begin
            on_t  = (MW'(duty_i[p]) * per_s) >>> FRAC;
            off_t = (per_s - on_t) >>> 1;
            if (off_t < 0)          cmp_c[p] = '0;
            else if (off_t > per_s) cmp_c[p] = per_i;
            else                    cmp_c[p] = off_t[PW-1:0];
        end

        // Hold each compare value until the next result
        always_ff @(posedge clk) begin
            if (!rst_n)     cmp_o[p] <= '0;
            else if (vld_i) cmp_o[p] <= cmp_c[p];
        end
    end

    // Sector output and one-cycle result strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= vld_i;
            if (vld_i) sect_o <= sect_i;
        end
    end
endmodule

// File: rtl/svm_timing_gen.sv
`timescale 1ns/1ps
// Space vector PWM timing generator, top level.
// Four-stage pipeline: capture, rotate/sector, active times, compare values.
// Assumes the command magnitude stays within the inscribed circle (1.0);
// larger commands are clamped at the outputs.
module svm_timing_gen #(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] valpha,
    input  logic signed [W-1:0] vbeta,
    input  logic [PW-1:0]       period,
    output logic [PW-1:0]       cmp_a,
    output logic [PW-1:0]       cmp_b,
    output logic [PW-1:0]       cmp_c,
    output logic [2:0]          sector,
    output logic                done
);
    localparam int IW = W + 2;

    logic                 vld1;
    logic signed [W-1:0]  alpha1;
    logic signed [W-1:0]  beta1;
    logic [PW-1:0]        per1;

    logic                 vld2;
    logic signed [IW-1:0] x2;
    logic signed [IW-1:0] y2;
    logic signed [IW-1:0] z2;
    logic [2:0]           code2;
    logic [PW-1:0]        per2;

    logic                 vld3;
    logic signed [IW-1:0] duty3 [3];
    logic [2:0]           sect3;
    logic [PW-1:0]        per3;

    logic [PW-1:0]        cmp4 [3];

    // Stage 1: capture the command and its period on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld1   <= 1'b0;
            alpha1 <= '0;
            beta1  <= '0;
            per1   <= '0;
        end else begin
            vld1 <= start;
            if (start) begin
                alpha1 <= valpha;
                beta1  <= vbeta;
                per1   <= period;
            end
        end
    end

    svm_ref_rotate #(.W(W), .PW(PW)) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (vld1),
        .alpha_i (alpha1),
        .beta_i  (beta1),
        .per_i   (per1),
        .vld_o   (vld2),
        .x_o     (x2),
        .y_o     (y2),
        .z_o     (z2),
        .code_o  (code2),
        .per_o   (per2)
    );

    svm_sector_times #(.W(W), .PW(PW)) u_times (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld2),
        .x_i    (x2),
        .y_i    (y2),
        .z_i    (z2),
        .code_i (code2),
        .per_i  (per2),
        .vld_o  (vld3),
        .duty_o (duty3),
        .sect_o (sect3),
        .per_o  (per3)
    );

    svm_compare_gen #(.W(W), .PW(PW)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld3),
        .duty_i (duty3),
        .sect_i (sect3),
        .per_i  (per3),
        .cmp_o  (cmp4),
        .sect_o (sector),
        .done_o (done)
    );

    // Map the phase array onto named outputs
    always_comb begin
        cmp_a = cmp4[0];
        cmp_b = cmp4[1];
        cmp_c = cmp4[2];
    end
endmodule

// File: rtl/svm_timing_chk.sv
`timescale 1ns/1ps
// Property checker for svm_timing_gen, attached by bind.
// Observes only the top-level ports.
module svm_timing_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [PW-1:0] period,
    input logic [PW-1:0] cmp_a,
    input logic [PW-1:0] cmp_b,
    input logic [PW-1:0] cmp_c,
    input logic [2:0]    sector,
    input logic          done
);
    logic [PW-1:0] c_lo;
    logic [PW-1:0] c_mid;
    logic [PW-1:0] c_hi;

    // Compare values of the first, second and third phase for this sector
    always_comb begin
        case (sector)
            3'd1:    begin c_lo = cmp_b; c_mid = cmp_a; c_hi = cmp_c; end
            3'd2:    begin c_lo = cmp_a; c_mid = cmp_c; c_hi = cmp_b; end
            3'd3:    begin c_lo = cmp_a; c_mid = cmp_b; c_hi = cmp_c; end
            3'd4:    begin c_lo = cmp_c; c_mid = cmp_b; c_hi = cmp_a; end
            3'd5:    begin c_lo = cmp_b; c_mid = cmp_c; c_hi = cmp_a; end
            default: begin c_lo = cmp_c; c_mid = cmp_a; c_hi = cmp_b; end
        endcase
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start, 4) |-> done); // R7
    AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 4)); // R7
    AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sector != 3'd7)); // R6
    AST_ZERO_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sector == 3'd0) |-> (cmp_a == cmp_b && cmp_b == cmp_c)); // R6
    AST_CMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmp_a <= $past(period, 4) && cmp_b <= $past(period, 4)
                  && cmp_c <= $past(period, 4))); // R5
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sector != 3'd0) |-> (c_lo >= c_mid && c_mid >= c_hi)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cmp_a) && $stable(cmp_b) && $stable(cmp_c)
                   && $stable(sector))); // R10
endmodule

bind svm_timing_gen svm_timing_chk #(.PW(PW)) u_chk (.*);

// File: tb/sim_svm_timing_gen.sv
`timescale 1ns/1ps
// Self-checking bench for svm_timing_gen: angle/magnitude/period sweeps
// against a real-valued model, plus zero vector, clamp, burst and hold cases.
module sim_svm_timing_gen;
    localparam int W    = 16;
    localparam int PW   = 16;
    localparam real ONE = 16384.0;
    localparam real S3H = 0.8660254037844386;
    localparam real PI  = 3.14159265358979;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic signed [W-1:0] valpha = '0;
    logic signed [W-1:0] vbeta = '0;
    logic [PW-1:0]       period = '0;
    logic [PW-1:0]       cmp_a;
    logic [PW-1:0]       cmp_b;
    logic [PW-1:0]       cmp_c;
    logic [2:0]          sector;
    logic                done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    svm_timing_gen #(.W(W), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .valpha(valpha), .vbeta(vbeta),
        .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .sector(sector), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic real rabs(input real r);
        return (r < 0.0) ? -r : r;
    endfunction

    // Real-valued model of R1..R5 on the quantized inputs
    function automatic void model(input int ia, input int ib, input int p,
                                  output real ea, output real eb, output real ec,
                                  output int code, output real marg);
        real a, b, x, y, z, t1, t2, bs;
        real d [3];
        real e [3];
        int o [3];
        a = ia / ONE;
        b = ib / ONE;
        x = b;
        y = b / 2.0 + S3H * a;
        z = b / 2.0 - S3H * a;
        code = (y < 0.0 ? 4 : 0) + (z < 0.0 ? 2 : 0) + (x > 0.0 ? 1 : 0);
        marg = rabs(x);
        if (rabs(y) < marg) marg = rabs(y);
        if (rabs(z) < marg) marg = rabs(z);
        case (code)
            1: begin t1 = z;  t2 = y;  o = '{1, 0, 2}; end
            2: begin t1 = y;  t2 = -x; o = '{0, 2, 1}; end
            3: begin t1 = -z; t2 = x;  o = '{0, 1, 2}; end
            4: begin t1 = -x; t2 = z;  o = '{2, 1, 0}; end
            5: begin t1 = x;  t2 = -y; o = '{1, 2, 0}; end
            6: begin t1 = -y; t2 = -z; o = '{2, 0, 1}; end
            default: begin t1 = 0.0; t2 = 0.0; o = '{0, 1, 2}; code = 0; end
        endcase
        bs = (1.0 - t1 - t2) / 2.0;
        d[o[0]] = bs;
        d[o[1]] = bs + t1;
        d[o[2]] = bs + t1 + t2;
        for (int k = 0; k < 3; k++) begin
            e[k] = (p - d[k] * p) / 2.0;
            if (e[k] < 0.0) e[k] = 0.0;
            if (e[k] > p) e[k] = p;
        end
        ea = e[0];
        eb = e[1];
        ec = e[2];
    endfunction

    task automatic check_result(input int ia, input int ib, input int p, input string tag);
        real ea, eb, ec, marg;
        int code, tol;
        model(ia, ib, p, ea, eb, ec, code, marg);
        tol = p / 1024 + 2;
        chk(rabs(real'(cmp_a) - ea) <= tol, {tag, " R2 R3 R4 cmp_a"}, cmp_a, rnd(ea));
        chk(rabs(real'(cmp_b) - eb) <= tol, {tag, " R2 R3 R4 cmp_b"}, cmp_b, rnd(eb));
        chk(rabs(real'(cmp_c) - ec) <= tol, {tag, " R2 R3 R4 cmp_c"}, cmp_c, rnd(ec));
        chk(cmp_a <= p && cmp_b <= p && cmp_c <= p, {tag, " R5 range"}, cmp_a, p);
        if (marg > 0.005 || code == 0)
            chk(sector == 3'(code), {tag, " R1 sector"}, sector, code);
    endtask

    // One command: start, check latency, then check the result
    task automatic run_one(input int ia, input int ib, input int p, input string tag);
        @(negedge clk);
        valpha = W'(ia);
        vbeta  = W'(ib);
        period = PW'(p);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, {tag, " R7 early done"}, done, 0);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R7 done"}, done, 1);
        check_result(ia, ib, p, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int mq [4];
        int pq [3];
        int za, zb, zc;
        mq = '{4915, 11469, 15565, 16384};
        pq = '{1000, 4095, 60000};

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 done in reset", done, 0);
        chk(cmp_a == 0 && cmp_b == 0 && cmp_c == 0, "R9 cmp in reset", cmp_a, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && sector == 3'd0, "R9 after reset", sector, 0);
        chk(cmp_a == 0 && cmp_b == 0 && cmp_c == 0, "R9 cmp after reset", cmp_b, 0);

        // R6: exact zero vector with even and odd periods
        run_one(0, 0, 1000, "zero");
        chk(cmp_a == 250 && cmp_b == 250 && cmp_c == 250, "R6 zero even", cmp_a, 250);
        run_one(0, 0, 999, "zero_odd");
        chk(cmp_a == 250 && cmp_b == 250 && cmp_c == 250, "R6 zero odd", cmp_c, 250);
        chk(sector == 3'd0, "R6 zero sector", sector, 0);

        // R1 R2 R3 R4 R8: sweep of angle, magnitude and period
        foreach (pq[pi_]) begin
            foreach (mq[mi]) begin
                for (int deg = 0; deg < 360; deg += 15) begin
                    real th;
                    th = deg * PI / 180.0;
                    run_one(rnd(mq[mi] * $cos(th)), rnd(mq[mi] * $sin(th)), pq[pi_], "sweep");
                end
            end
        end

        // R1: axis vector lies in sector 1 exactly
        run_one(0, 16384, 2000, "axis");
        chk(sector == 3'd1, "R1 beta axis sector", sector, 1);

        // R5: over-range commands saturate
        for (int deg = 0; deg < 360; deg += 30) begin
            real th;
            th = deg * PI / 180.0;
            run_one(rnd(26214 * $cos(th)), rnd(26214 * $sin(th)), 2000, "R5 overdrive");
        end

        // R7 R8: three back-to-back commands with different periods
        @(negedge clk);
        valpha = W'(8000);  vbeta = W'(3000);   period = PW'(1200);  start = 1'b1;
        @(negedge clk);
        valpha = W'(-9000); vbeta = W'(5000);   period = PW'(30000); start = 1'b1;
        @(negedge clk);
        valpha = W'(-2000); vbeta = W'(-12000); period = PW'(5000);  start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R7 burst done 1", done, 1);
        check_result(8000, 3000, 1200, "R8 burst 1");
        @(negedge clk);
        chk(done == 1'b1, "R7 burst done 2", done, 1);
        check_result(-9000, 5000, 30000, "R8 burst 2");
        @(negedge clk);
        chk(done == 1'b1, "R7 burst done 3", done, 1);
        check_result(-2000, -12000, 5000, "R8 burst 3");
        @(negedge clk);
        chk(done == 1'b0, "R7 burst end", done, 0);

        // R10: outputs hold while inputs move without start
        za = cmp_a; zb = cmp_b; zc = cmp_c;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            valpha = W'(k * 1500);
            vbeta  = W'(-k * 900);
            period = PW'(100 + k);
        end
        @(negedge clk);
        chk(cmp_a == za && cmp_b == zb && cmp_c == zc, "R10 hold cmp", cmp_a, za);
        chk(done == 1'b0, "R10 no done", done, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule